// File: doc/BRIEF.md
# PCI Configuration Access Sequencer

This block sits on the host side of a PCI bridge and turns a single configuration request from the processor into one configuration cycle on a simple bus master port. A request names a bus, a device/function byte, a register offset, an access size (byte, word or dword), a direction and, for writes, the data. The sequencer decides whether the target lives on the local bus (bus 0) or behind a bridge, builds the matching configuration address and folds it into a sparse address that also encodes the access size. It then runs exactly one transfer on the master port, moves data between the request and the correct byte lanes, and reports the result.

Targets behind a bridge need a cycle-type field in a shared bridge control register. The block owns that register: software may load it while the block is idle, and around every bridged access the sequencer saves it with the cycle-type bits cleared, marks it for a bridged cycle, runs the access and writes the saved value back. Because the register is shared, only one request is in flight at a time and requests that arrive while the block is busy are dropped. A read that is aborted, by an error response or by a missing acknowledge, returns all-ones data instead of an error, and an aborted write completes quietly.

Top module: `pcicfg_seq`

## Requirements
- R1: After reset `busy`, `doneValid` and `mValid` are low and `cfgCtrl` is zero.
- R2: On bus 0 the configuration address is a one-hot device select equal to 0x800 shifted left by the device number (devFn bits 7:3), ORed with the function (devFn bits 2:0) in bits 10:8 and the full offset byte in bits 7:0.
- R3: On bus 0 a device number above 8 completes with `doneNotFound` high, `doneRdata` zero, no `mValid` pulse and `cfgCtrl` unchanged; device 8 is accepted.
- R4: On a non-zero bus the configuration address is the bus in bits 23:16, devFn in bits 15:8 and the offset byte in bits 7:0, with bits 31:24 zero.
- R5: `mAddr` equals the configuration address shifted left by 5, plus a size code (size 0 byte: 0x00, size 1 word: 0x08, size 2 or 3 dword: 0x18), plus the parameter `CFG_BASE`; `mWrite` follows the request direction.
- R6: On a write, `mWdata` is the request data masked to the access width (8, 16 or 32 bits) and, for byte and word, shifted left by 8 times offset bits 1:0; dwords are not shifted.
- R7: On a successful read, `doneRdata` is `mRdata` shifted right by 8 times offset bits 1:0 (byte and word only), then masked to the access width.
- R8: For a bridged access `cfgCtrl` reads (old AND 0x3FFFFFFF) OR 0x40000000 while `mValid` is high and old AND 0x3FFFFFFF after completion; a bus 0 access leaves it unchanged. While idle, `hostCtrlWe` loads `hostCtrlData` into `cfgCtrl`.
- R9: A read answered with `mErr` returns all-ones masked to the access width with `doneNotFound` low; an aborted write also completes with `doneNotFound` low.
- R10: If no acknowledge arrives within `TIMEOUT` cycles of the transfer starting, the access is aborted as in R9, `mValid` is low and `doneValid` rises between `TIMEOUT` and `TIMEOUT+6` cycles after the request.
- R11: While `busy` is high, new requests and control register loads are ignored, and `mValid` is only high while `busy` is high.
- R12: Every accepted request yields exactly one single-cycle `doneValid` pulse, during which `busy` is still high; `busy` is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken only when idle |
| reqBus | input | 8 | Target bus number |
| reqDevFn | input | 8 | Device (7:3) and function (2:0) |
| reqOffset | input | 8 | Configuration register byte offset |
| reqSize | input | 2 | 0 byte, 1 word, 2 or 3 dword |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqWdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | A request is being processed |
| doneValid | output | 1 | One-cycle completion pulse |
| doneNotFound | output | 1 | Target rejected, no cycle issued |
| doneRdata | output | 32 | Right-aligned read result |
| hostCtrlWe | input | 1 | Load the bridge control register (idle only) |
| hostCtrlData | input | 32 | Value for the bridge control register |
| cfgCtrl | output | 32 | Bridge control register, bits 31:30 carry the cycle type |
| mValid | output | 1 | Master port transfer request |
| mWrite | output | 1 | Master port direction |
| mAddr | output | ADDR_W | Sparse configuration address |
| mWdata | output | 32 | Lane-aligned write data |
| mReady | input | 1 | Slave takes the transfer |
| mAck | input | 1 | Slave completes the transfer |
| mErr | input | 1 | Completion is a master abort |
| mRdata | input | 32 | Read data, valid with mAck |

## Verification
A request taken at one edge reaches the check state on that edge and the master port one edge later for bus 0 targets, two edges later for bridged ones, so the bench watches every falling edge after the request and checks the address, write data and control register on the first one where `mValid` is high rather than at a fixed count. The completion pulse comes two edges after the acknowledge for a bridged access (restore then done) and one edge after for bus 0; the bench samples the result on the falling edge where `doneValid` is seen and checks idle and the restored control register on the following falling edge. The timeout case is bounded by counting falling edges from the request to the pulse.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SETCFG,
    ST_ACCESS,
    ST_WAITACK,
    ST_RESTORE,
    ST_DONE
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic latchReq;
    logic setCfg;
    logic restoreCfg;
    logic capResp;
    logic capAbort;
    logic hostWr;
  } dpStrobe_t;

  // decoded facts about the latched request, back to the sequencer
  typedef struct packed {
    logic notFound;
    logic isType1;
  } dpFlags_t;

  localparam logic [1:0]  SZ_BYTE   = 2'd0;
  localparam logic [1:0]  SZ_WORD   = 2'd1;
  localparam logic [31:0] CYC_MASK  = 32'hC000_0000;
  localparam logic [31:0] CYC_TYPE1 = 32'h4000_0000;

endpackage

// File: rtl/pcicfg_ctrl.sv
module pcicfg_ctrl
  import pcicfg_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      hostCtrlWe,
  input  dpFlags_t  flags,
  input  logic      mReady,
  input  logic      mAck,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      doneValid,
  output logic      mValid
);

  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

  seqState_t state, nextState;
  logic [CNT_W-1:0] tmoCnt;
  logic tmoHit;
  seqState_t afterXfer;

  assign tmoHit    = (tmoCnt == CNT_LAST);
  assign afterXfer = flags.isType1 ? ST_RESTORE : ST_DONE;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        strobe.hostWr = hostCtrlWe;
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          nextState       = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (flags.notFound)     nextState = ST_DONE;
        else if (flags.isType1) nextState = ST_SETCFG;
        else                    nextState = ST_ACCESS;
      end
      ST_SETCFG: begin
        strobe.setCfg = 1'b1;
        nextState     = ST_ACCESS;
      end
      ST_ACCESS: begin
        if (mReady) nextState = ST_WAITACK;
        else if (tmoHit) begin
          strobe.capAbort = 1'b1;
          nextState       = afterXfer;
        end
      end
      ST_WAITACK: begin
        if (mAck) begin
          strobe.capResp = 1'b1;
          nextState      = afterXfer;
        end else if (tmoHit) begin
          strobe.capAbort = 1'b1;
          nextState       = afterXfer;
        end
      end
      ST_RESTORE: begin
        strobe.restoreCfg = 1'b1;
        nextState         = ST_DONE;
      end
      ST_DONE:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      tmoCnt <= '0;
    end else begin
      state <= nextState;
      if (state == ST_ACCESS || state == ST_WAITACK) tmoCnt <= tmoCnt + 1'b1;
      else                                           tmoCnt <= '0;
    end
  end

  assign busy      = (state != ST_IDLE);
  assign doneValid = (state == ST_DONE);
  assign mValid    = (state == ST_ACCESS);

endmodule

// File: rtl/pcicfg_dp.sv
module pcicfg_dp
  import pcicfg_pkg::*;
#(
  parameter int                ADDR_W   = 40,
  parameter logic [ADDR_W-1:0] CFG_BASE = '0,
  parameter int                MAX_DEV  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [7:0]        reqBus,
  input  logic [7:0]        reqDevFn,
  input  logic [7:0]        reqOffset,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [31:0]       reqWdata,
  input  logic [31:0]       hostCtrlData,
  input  logic              mErr,
  input  logic [31:0]       mRdata,
  output dpFlags_t          flags,
  output logic [31:0]       cfgCtrl,
  output logic [ADDR_W-1:0] mAddr,
  output logic              mWrite,
  output logic [31:0]       mWdata,
  output logic              doneNotFound,
  output logic [31:0]       doneRdata
);

  localparam int PAD_W = ADDR_W - 32;

  logic [7:0]  rBus, rDevFn, rOff;
  logic [1:0]  rSize;
  logic        rWrite;
  logic [31:0] rWdata;
  logic [31:0] savedCtrl;

  logic [31:0]       cfgAddr;
  logic [ADDR_W-1:0] sizeCode;
  logic [31:0]       sizeMask;
  logic [4:0]        laneShift;
  logic [31:0]       rdSource;

  // target decode
  assign flags.isType1  = (rBus != 8'd0);
  assign flags.notFound = !flags.isType1 && (int'(rDevFn[7:3]) > MAX_DEV);

  always_comb begin
    if (flags.isType1) cfgAddr = {8'd0, rBus, rDevFn, rOff};
    else               cfgAddr = (32'h800 << rDevFn[7:3]) | {21'd0, rDevFn[2:0], rOff};
  end

  // size code, width mask and lane shift
  always_comb begin
    unique case (rSize)
      SZ_BYTE: begin sizeCode = ADDR_W'(8'h00); sizeMask = 32'h0000_00FF; end
      SZ_WORD: begin sizeCode = ADDR_W'(8'h08); sizeMask = 32'h0000_FFFF; end
      default: begin sizeCode = ADDR_W'(8'h18); sizeMask = 32'hFFFF_FFFF; end
    endcase
    laneShift = rSize[1] ? 5'd0 : {rOff[1:0], 3'b000};
  end

  assign mAddr  = ({{PAD_W{1'b0}}, cfgAddr} << 5) + sizeCode + CFG_BASE;
  assign mWrite = rWrite;
  assign mWdata = (rWdata & sizeMask) << laneShift;

  assign rdSource = (strobe.capAbort || mErr) ? 32'hFFFF_FFFF : mRdata;
  assign doneNotFound = flags.notFound;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rBus      <= '0;
      rDevFn    <= '0;
      rOff      <= '0;
      rSize     <= '0;
      rWrite    <= 1'b0;
      rWdata    <= '0;
      cfgCtrl   <= '0;
      savedCtrl <= '0;
      doneRdata <= '0;
    end else begin
      if (strobe.latchReq) begin
        rBus      <= reqBus;
        rDevFn    <= reqDevFn;
        rOff      <= reqOffset;
        rSize     <= reqSize;
        rWrite    <= reqWrite;
        rWdata    <= reqWdata;
        doneRdata <= '0;
      end
      if (strobe.hostWr) cfgCtrl <= hostCtrlData;
      if (strobe.setCfg) begin
        savedCtrl <= cfgCtrl & ~CYC_MASK;
        cfgCtrl   <= (cfgCtrl & ~CYC_MASK) | CYC_TYPE1;
      end
      if (strobe.restoreCfg) cfgCtrl <= savedCtrl;
      if ((strobe.capResp || strobe.capAbort) && !rWrite)
        doneRdata <= (rdSource >> laneShift) & sizeMask;
    end
  end

endmodule

// File: rtl/pcicfg_seq.sv
module pcicfg_seq
  import pcicfg_pkg::*;
#(
  parameter int                ADDR_W   = 40,
  parameter logic [ADDR_W-1:0] CFG_BASE = 40'h80_0000_0000,
  parameter int                MAX_DEV  = 8,
  parameter int                TIMEOUT  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [7:0]        reqBus,
  input  logic [7:0]        reqDevFn,
  input  logic [7:0]        reqOffset,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [31:0]       reqWdata,
  output logic              busy,
  output logic              doneValid,
  output logic              doneNotFound,
  output logic [31:0]       doneRdata,
  input  logic              hostCtrlWe,
  input  logic [31:0]       hostCtrlData,
  output logic [31:0]       cfgCtrl,
  output logic              mValid,
  output logic              mWrite,
  output logic [ADDR_W-1:0] mAddr,
  output logic [31:0]       mWdata,
  input  logic              mReady,
  input  logic              mAck,
  input  logic              mErr,
  input  logic [31:0]       mRdata
);

  dpStrobe_t strobe;
  dpFlags_t  flags;

  pcicfg_ctrl #(.TIMEOUT(TIMEOUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .hostCtrlWe(hostCtrlWe),
    .flags(flags), .mReady(mReady), .mAck(mAck), .strobe(strobe),
    .busy(busy), .doneValid(doneValid), .mValid(mValid)
  );

  pcicfg_dp #(.ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE), .MAX_DEV(MAX_DEV)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqBus(reqBus), .reqDevFn(reqDevFn), .reqOffset(reqOffset),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .hostCtrlData(hostCtrlData), .mErr(mErr), .mRdata(mRdata),
    .flags(flags), .cfgCtrl(cfgCtrl), .mAddr(mAddr), .mWrite(mWrite),
    .mWdata(mWdata), .doneNotFound(doneNotFound), .doneRdata(doneRdata)
  );

endmodule

// File: rtl/pcicfg_seq_chk.sv
module pcicfg_seq_chk #(
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              doneValid,
  input logic              hostCtrlWe,
  input logic [31:0]       cfgCtrl,
  input logic              mValid,
  input logic              mReady,
  input logic [ADDR_W-1:0] mAddr
);

  // R11: the master port is only driven during a request
  p_valid_in_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    mValid |-> busy);

  // R12: completion is a single-cycle pulse
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R12: completion is reported while still busy
  p_done_busy_r12: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> busy);

  // R5: the address holds while the transfer waits
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mValid && !mReady) |=> $stable(mAddr));

  // R11: an idle cycle without a load leaves the control register alone
  p_ctrl_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !hostCtrlWe) |=> $stable(cfgCtrl));

endmodule

bind pcicfg_seq pcicfg_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .doneValid(doneValid),
  .hostCtrlWe(hostCtrlWe), .cfgCtrl(cfgCtrl), .mValid(mValid),
  .mReady(mReady), .mAddr(mAddr)
);

// File: tb/pcicfg_seq_tb.sv
module pcicfg_seq_tb;

  localparam int          ADDR_W  = 40;
  localparam logic [39:0] BASE    = 40'h80_0000_0000;
  localparam int          TIMEOUT = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [7:0]  reqBus = '0, reqDevFn = '0, reqOffset = '0;
  logic [1:0]  reqSize = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqWdata = '0;
  logic        busy, doneValid, doneNotFound;
  logic [31:0] doneRdata;
  logic        hostCtrlWe = 1'b0;
  logic [31:0] hostCtrlData = '0;
  logic [31:0] cfgCtrl;
  logic        mValid, mWrite;
  logic [39:0] mAddr;
  logic [31:0] mWdata;
  logic        mReady = 1'b0, mAck = 1'b0, mErr = 1'b0;
  logic [31:0] mRdata = '0;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] expCtrl = '0;

  always #10 clk = ~clk;

  pcicfg_seq #(.ADDR_W(ADDR_W), .CFG_BASE(BASE), .MAX_DEV(8), .TIMEOUT(TIMEOUT)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBus(reqBus),
    .reqDevFn(reqDevFn), .reqOffset(reqOffset), .reqSize(reqSize),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .busy(busy),
    .doneValid(doneValid), .doneNotFound(doneNotFound), .doneRdata(doneRdata),
    .hostCtrlWe(hostCtrlWe), .hostCtrlData(hostCtrlData), .cfgCtrl(cfgCtrl),
    .mValid(mValid), .mWrite(mWrite), .mAddr(mAddr), .mWdata(mWdata),
    .mReady(mReady), .mAck(mAck), .mErr(mErr), .mRdata(mRdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] fAddr(logic [7:0] bus, logic [7:0] devFn, logic [7:0] off, logic [1:0] size);
    logic [31:0] ca;
    logic [39:0] sc;
    if (bus == 8'd0) ca = (32'h800 << devFn[7:3]) | {21'd0, devFn[2:0], off};
    else             ca = {8'd0, bus, devFn, off};
    sc = (size == 2'd0) ? 40'h00 : (size == 2'd1) ? 40'h08 : 40'h18;
    return ({8'd0, ca} << 5) + sc + BASE;
  endfunction

  function automatic logic [31:0] fMask(logic [1:0] size);
    return (size == 2'd0) ? 32'hFF : (size == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic int fLane(logic [1:0] size, logic [7:0] off);
    return size[1] ? 0 : 8 * int'(off[1:0]);
  endfunction

  task automatic hostWrite(input logic [31:0] d);
    @(negedge clk);
    hostCtrlWe = 1'b1; hostCtrlData = d;
    @(negedge clk);
    hostCtrlWe = 1'b0;
    expCtrl = d;
    chk(cfgCtrl == d, "R8 idle load", cfgCtrl, d);
  endtask

  // mode: 0 normal, 1 error completion, 2 no acknowledge
  task automatic runAccess(input logic [7:0] bus, input logic [7:0] devFn, input logic [7:0] off,
                           input logic [1:0] size, input logic wr, input logic [31:0] wdata,
                           input logic [31:0] rdata, input int mode, input int readyDly,
                           input bit poke);
    bit notFound = (bus == 8'd0) && (devFn[7:3] > 5'd8);
    bit type1 = (bus != 8'd0);
    bit accepted = 0, acked = 0, seenValid = 0, gotDone = 0;
    int waitCnt = 0, doneAt = 0;
    logic [31:0] ctrlOld = expCtrl;
    logic [31:0] expData;
    @(negedge clk);
    reqValid = 1'b1; reqBus = bus; reqDevFn = devFn; reqOffset = off;
    reqSize = size; reqWrite = wr; reqWdata = wdata;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      reqValid = 1'b0; mReady = 1'b0; mAck = 1'b0; mErr = 1'b0;
      if (poke && i == 1) begin
        reqValid = 1'b1; reqBus = bus + 8'd1; reqOffset = off ^ 8'h40;
        hostCtrlWe = 1'b1; hostCtrlData = 32'h1357_9BDF;
      end
      if (poke && i == 2) begin
        reqValid = 1'b0; hostCtrlWe = 1'b0;
      end
      if (doneValid) begin
        gotDone = 1; doneAt = i;
        break;
      end
      if (mValid && !accepted) begin
        if (!seenValid) begin
          seenValid = 1;
          chk(mAddr == fAddr(bus, devFn, off, size), type1 ? "R4/R5 bridged addr" : "R2/R5 local addr",
              mAddr, fAddr(bus, devFn, off, size));
          chk(mWrite == wr, "R5 direction", mWrite, wr);
          if (wr) chk(mWdata == ((wdata & fMask(size)) << fLane(size, off)), "R6 write lanes",
                      mWdata, (wdata & fMask(size)) << fLane(size, off));
          if (type1) chk(cfgCtrl == ((ctrlOld & 32'h3FFF_FFFF) | 32'h4000_0000), "R8 set cycle type",
                         cfgCtrl, (ctrlOld & 32'h3FFF_FFFF) | 32'h4000_0000);
          else chk(cfgCtrl == ctrlOld, "R8 local keeps ctrl", cfgCtrl, ctrlOld);
          if (notFound) chk(0, "R3 cycle on rejected device", 1, 0);
        end
        if (waitCnt >= readyDly) begin
          mReady = 1'b1; accepted = 1;
        end
        waitCnt++;
      end else if (accepted && !acked && mode != 2) begin
        mAck = 1'b1; mErr = (mode == 1); mRdata = rdata; acked = 1;
      end
    end
    chk(gotDone, "R12 completion seen", gotDone, 1);
    if (notFound) begin
      chk(doneNotFound == 1'b1, "R3 not found", doneNotFound, 1);
      chk(!seenValid, "R3 no cycle", seenValid, 0);
      chk(doneRdata == 32'd0, "R3 no data", doneRdata, 0);
    end else begin
      chk(doneNotFound == 1'b0, "R9 status ok", doneNotFound, 0);
      if (!wr) begin
        if (mode == 0) expData = (rdata >> fLane(size, off)) & fMask(size);
        else           expData = fMask(size);
        chk(doneRdata == expData, mode == 0 ? "R7 read lanes" : "R9 abort data", doneRdata, expData);
      end
      if (mode == 2) begin
        chk(!mValid, "R10 valid dropped", mValid, 0);
        chk(doneAt >= TIMEOUT && doneAt <= TIMEOUT + 6, "R10 timeout window", doneAt, TIMEOUT);
      end
    end
    @(negedge clk);
    chk(!doneValid && !busy, "R12 back to idle", {doneValid, busy}, 0);
    if (type1 && !notFound) expCtrl = ctrlOld & 32'h3FFF_FFFF;
    chk(cfgCtrl == expCtrl, poke ? "R11 load ignored when busy" : "R8 restored ctrl", cfgCtrl, expCtrl);
  endtask

  initial begin
    #(20 * 150000);
    nFails++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!busy && !doneValid && !mValid, "R1 reset outputs", {busy, doneValid, mValid}, 0);
    chk(cfgCtrl == 32'd0, "R1 reset ctrl", cfgCtrl, 0);
    rstN = 1'b1;
    @(negedge clk);

    // directed corners
    runAccess(8'd0, {5'd8, 3'd2}, 8'h11, 2'd0, 1'b0, 0, 32'hA1B2_C3D4, 0, 0, 0); // R2 device 8 accepted
    runAccess(8'd0, {5'd9, 3'd0}, 8'h00, 2'd2, 1'b0, 0, 32'h0, 0, 0, 0);          // R3 rejected
    hostWrite(32'hC000_1234);
    runAccess(8'd3, 8'h5A, 8'h06, 2'd1, 1'b1, 32'h0000_BEEF, 0, 0, 1, 0);        // R4 R6 R8
    runAccess(8'd0, {5'd2, 3'd1}, 8'h43, 2'd0, 1'b0, 0, 32'h1234_5678, 1, 0, 0); // R9 error read
    runAccess(8'd0, {5'd1, 3'd0}, 8'h02, 2'd1, 1'b0, 0, 32'h0, 2, 0, 0);          // R10 timeout read
    hostWrite(32'h8000_00F0);
    runAccess(8'd7, 8'h08, 8'h10, 2'd2, 1'b1, 32'hCAFE_F00D, 0, 2, 0, 0);         // R10 timeout write
    runAccess(8'd0, {5'd4, 3'd0}, 8'h20, 2'd2, 1'b1, 32'h0102_0304, 0, 1, 2, 1);  // R11 poke, R9 write abort
    runAccess(8'd0, {5'd0, 3'd7}, 8'hFE, 2'd1, 1'b0, 0, 32'h89AB_CDEF, 0, 3, 0);  // R7 upper word

    // constrained random mix
    for (int n = 0; n < 60; n++) begin
      logic [7:0] b, df, of;
      logic [1:0] sz;
      int md;
      b  = ($urandom % 3 == 0) ? 8'($urandom) : 8'd0;
      df = {5'($urandom % 13), 3'($urandom)};
      of = 8'($urandom);
      sz = 2'($urandom % 4);
      md = ($urandom % 8 == 0) ? 1 : 0;
      if ($urandom % 5 == 0) hostWrite($urandom);
      runAccess(b, df, of, sz, 1'($urandom), $urandom, $urandom, md, int'($urandom % 4), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule